// File: doc/BRIEF.md
# Dark Reference Level Estimator

This block sits on a tagged sensor pixel stream and tracks the dark level of every readout channel. It samples the shielded columns at the start of each line. Only the inner part of the shielded band counts, because stray light reaches the shielded pixels that lie nearest to lit areas. It then keeps a smoothed dark estimate for each channel. Image pixels leave the block with that estimate removed, clamped at zero. Every other pixel passes through unchanged.

The block locates each pixel from two inputs: a column count that restarts at every line half, and a row index. One channel of the line is taken as a half. In a layout with one readout chain, channel 0 carries the whole line. In a layout with two chains, each half-line has its own channel number. The same column decoding serves both layouts. Each half-line starts with 2 empty shift slots. Then come 14 shielded columns, 2 buffer columns and `ACT_W` image columns. Each frame opens with 2 shielded rows and 2 buffer rows. Then come `ACT_H` image rows, 2 buffer rows and 2 shielded rows.

Top module: `dark_ref_est`

## Requirements
- R1: A sample contributes to the dark estimate only if its half-line column count is 4 to 13 inclusive and its row is 2 to ACT_H+5 inclusive. Column 0 is the first empty shift slot and row 0 is the first frame row. Samples from the empty slots, the outer two shielded columns on either side, the shielded rows and all other positions never contribute.
- R2: For each channel and each line, the block sums the 10 qualifying samples. When the column-13 sample arrives, it forms the line mean as floor(sum/10) and updates the estimate in that same cycle. The new estimate appears on `dark_lvl` one cycle later.
- R3: Once the estimate has been seeded, each update sets it to dark + ((mean - dark) >>> k). The shift is arithmetic and k = `ema_shift` + 1, so k ranges from 1 to 8.
- R4: A valid pixel at row 0, column 0 of a channel starts a new frame for that channel. The first line mean after that point replaces the channel's estimate directly, with no averaging.
- R5: Image pixels are those in rows 4 to ACT_H+3 and columns 18 to ACT_W+17. For each one, `out_data` equals the raw value minus the channel's current estimate, or 0 if the raw value is smaller. The current estimate is the value shown on `dark_lvl` in the cycle of input. `out_img` is 1 for these pixels.
- R6: All valid non-image pixels come out with `out_data` equal to the raw value and `out_img` at 0.
- R7: `out_valid` follows `pix_valid` with one cycle of latency. A cycle with `pix_valid` low changes no estimate, whatever the other inputs carry.
- R8: Each channel's estimate is updated only by pixels tagged with that channel. Each image pixel is corrected with the estimate of its own channel. `dark_lvl` packs channel i at bits [i*DW +: DW].
- R9: While `rst` is high, at the clock edge all estimates go to 0 and `out_valid` and `out_img` go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ema_shift | input | 3 | Smoothing shift minus one (k = value + 1) |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_data | input | DW | Raw pixel value |
| pix_col | input | CW | Column count within the half-line, 0 at the first empty slot |
| pix_row | input | RW | Row index within the frame |
| pix_ch | input | CHW | Readout channel of the pixel |
| out_valid | output | 1 | Output pixel qualifier |
| out_data | output | DW | Corrected (image) or raw (other) pixel value |
| out_img | output | 1 | Output pixel is an image pixel |
| dark_lvl | output | NCH*DW | Current dark estimate per channel |

## Verification
The hardest behaviour to reach from the ports is the difference between seeding and smoothing. A mistake there shows only when one frame's dark level differs sharply from the previous frame's, and only on the first line after the frame restarts. The stimulus therefore moves the dark base of each channel by large steps from frame to frame. It changes the smoothing shift between frames and alternates interleaved two-channel frames with frames on one channel only. The leaky shielded columns and the shielded rows are filled with values far above the dark base, so any sample counted from outside the trusted window moves the estimate visibly. Idle cycles carry random column, row and data values to show that they are ignored.

// File: rtl/drk_pkg.sv
package drk_pkg;
  // Fixed line and frame geometry around the active image
  localparam int EMPTY_CYC   = 2;   // empty shift slots opening each half-line
  localparam int SHIELD_COLS = 14;  // shielded columns per band
  localparam int LEAK_BORDER = 2;   // untrusted shielded pixels next to lit regions
  localparam int BUF_PIX     = 2;   // buffer ring width around the image
  localparam int SHIELD_ROWS = 2;   // shielded rows at each frame edge
  localparam int NTRUST      = SHIELD_COLS - 2 * LEAK_BORDER;

  typedef struct packed {
    logic trust;       // sample feeds the dark sum
    logic trust_last;  // final trusted sample of the line
    logic line_first;  // first slot of a half-line
    logic frame_first; // first slot of a frame
    logic image;       // active image pixel
  } pos_cls_t;
endpackage

// File: rtl/drk_classify.sv
module drk_classify
  import drk_pkg::*;
#(
  parameter int CW    = 11,
  parameter int RW    = 11,
  parameter int ACT_W = 512,
  parameter int ACT_H = 1024
) (
  input  logic [CW-1:0] col,
  input  logic [RW-1:0] row,
  output pos_cls_t      cls
);
  localparam int TC_LO = EMPTY_CYC + LEAK_BORDER;
  localparam int TC_HI = EMPTY_CYC + SHIELD_COLS - LEAK_BORDER - 1;
  localparam int IC_LO = EMPTY_CYC + SHIELD_COLS + BUF_PIX;
  localparam int IC_HI = IC_LO + ACT_W - 1;
  localparam int DR_LO = SHIELD_ROWS;
  localparam int DR_HI = SHIELD_ROWS + 2 * BUF_PIX + ACT_H - 1;
  localparam int IR_LO = SHIELD_ROWS + BUF_PIX;
  localparam int IR_HI = IR_LO + ACT_H - 1;

  logic dark_row, img_row, trust_col, img_col;

  always_comb begin
    dark_row  = (row >= RW'(DR_LO)) && (row <= RW'(DR_HI));
    img_row   = (row >= RW'(IR_LO)) && (row <= RW'(IR_HI));
    trust_col = (col >= CW'(TC_LO)) && (col <= CW'(TC_HI));
    img_col   = (col >= CW'(IC_LO)) && (col <= CW'(IC_HI));
    cls.trust       = dark_row && trust_col;
    cls.trust_last  = dark_row && (col == CW'(TC_HI));
    cls.line_first  = (col == '0);
    cls.frame_first = (col == '0) && (row == '0);
    cls.image       = img_row && img_col;
  end
endmodule

// File: rtl/drk_chan_avg.sv
module drk_chan_avg
  import drk_pkg::*;
#(
  parameter int DW = 12,
  localparam int SW = DW + $clog2(NTRUST)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,        // valid pixel on this channel
  input  pos_cls_t      cls,
  input  logic [DW-1:0] data,
  input  logic [2:0]    ema_shift,
  output logic [DW-1:0] dark
);
  logic [SW-1:0]        sum_q, total;
  logic [DW-1:0]        mean, ema_val;
  logic                 seeded_q;
  logic signed [DW:0]   diff, step, next;
  logic [3:0]           k_amt;

  always_comb begin
    total   = sum_q + SW'(data);
    mean    = DW'(total / SW'(NTRUST));
    k_amt   = {1'b0, ema_shift} + 4'd1;
    diff    = $signed({1'b0, mean}) - $signed({1'b0, dark});
    step    = diff >>> k_amt;
    next    = $signed({1'b0, dark}) + step;
    ema_val = next[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q    <= '0;
      dark     <= '0;
      seeded_q <= 1'b0;
    end else if (hit) begin
      if (cls.frame_first) seeded_q <= 1'b0;
      if (cls.line_first)  sum_q    <= '0;
      if (cls.trust) begin
        if (cls.trust_last) begin
          sum_q    <= '0;
          dark     <= seeded_q ? ema_val : mean;
          seeded_q <= 1'b1;
        end else begin
          sum_q <= total;
        end
      end
    end
  end
endmodule

// File: rtl/drk_correct.sv
module drk_correct #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_img,
  input  logic [DW-1:0] in_data,
  input  logic [DW-1:0] dark_sel,
  output logic          out_valid,
  output logic          out_img,
  output logic [DW-1:0] out_data
);
  logic [DW-1:0] cor;

  always_comb cor = (in_data > dark_sel) ? in_data - dark_sel : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_img   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_img   <= in_valid && in_img;
      out_data  <= in_img ? cor : in_data;
    end
  end
endmodule

// File: rtl/dark_ref_est.sv
module dark_ref_est
  import drk_pkg::*;
#(
  parameter int DW    = 12,
  parameter int CW    = 11,
  parameter int RW    = 11,
  parameter int NCH   = 2,
  parameter int ACT_W = 512,
  parameter int ACT_H = 1024,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        ema_shift,
  input  logic              pix_valid,
  input  logic [DW-1:0]     pix_data,
  input  logic [CW-1:0]     pix_col,
  input  logic [RW-1:0]     pix_row,
  input  logic [CHW-1:0]    pix_ch,
  output logic              out_valid,
  output logic [DW-1:0]     out_data,
  output logic              out_img,
  output logic [NCH*DW-1:0] dark_lvl
);
  pos_cls_t      cls;
  logic [DW-1:0] dark_q [NCH];
  logic [DW-1:0] dark_sel;

  drk_classify #(.CW(CW), .RW(RW), .ACT_W(ACT_W), .ACT_H(ACT_H)) u_cls (
    .col(pix_col), .row(pix_row), .cls(cls)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    drk_chan_avg #(.DW(DW)) u_avg (
      .clk(clk), .rst(rst),
      .hit(pix_valid && (pix_ch == CHW'(i))),
      .cls(cls), .data(pix_data), .ema_shift(ema_shift),
      .dark(dark_q[i])
    );
    assign dark_lvl[i*DW +: DW] = dark_q[i];
  end

  always_comb begin
    dark_sel = '0;
    for (int i = 0; i < NCH; i++)
      if (pix_ch == CHW'(i)) dark_sel = dark_q[i];
  end

  drk_correct #(.DW(DW)) u_cor (
    .clk(clk), .rst(rst),
    .in_valid(pix_valid), .in_img(cls.image), .in_data(pix_data),
    .dark_sel(dark_sel),
    .out_valid(out_valid), .out_img(out_img), .out_data(out_data)
  );
endmodule

// File: rtl/drk_chk.sv
module drk_chk #(
  parameter int DW  = 12,
  parameter int NCH = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              pix_valid,
  input logic [DW-1:0]     pix_data,
  input logic              out_valid,
  input logic [DW-1:0]     out_data,
  input logic              out_img,
  input logic [NCH*DW-1:0] dark_lvl
);
  p_valid_lat_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(pix_valid)));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pix_valid)) |-> $stable(dark_lvl));

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && out_valid && out_img) |-> (out_data <= $past(pix_data)));

  p_pass_raw_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && out_valid && !out_img) |-> (out_data == $past(pix_data)));

  p_img_qual_r5: assert property (@(posedge clk) disable iff (rst)
    out_img |-> out_valid);
endmodule

bind dark_ref_est drk_chk #(.DW(DW), .NCH(NCH)) u_drk_chk (
  .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_data(pix_data),
  .out_valid(out_valid), .out_data(out_data), .out_img(out_img),
  .dark_lvl(dark_lvl)
);

// File: tb/test_dark_ref_est.sv
module test_dark_ref_est;
  localparam int DW = 12, CW = 11, RW = 11, NCH = 2, AW = 8, AH = 6;
  localparam int ROWS = AH + 8;
  localparam int COLS = AW + 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] ema_shift = 3'd0;
  logic pix_valid = 1'b0;
  logic [DW-1:0] pix_data = '0;
  logic [CW-1:0] pix_col = '0;
  logic [RW-1:0] pix_row = '0;
  logic [0:0] pix_ch = '0;
  logic out_valid, out_img;
  logic [DW-1:0] out_data;
  logic [NCH*DW-1:0] dark_lvl;

  always #5 clk = ~clk;

  dark_ref_est #(.DW(DW), .CW(CW), .RW(RW), .NCH(NCH), .ACT_W(AW), .ACT_H(AH)) i_dark_ref_est (
    .clk(clk), .rst(rst), .ema_shift(ema_shift), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_col(pix_col), .pix_row(pix_row), .pix_ch(pix_ch),
    .out_valid(out_valid), .out_data(out_data), .out_img(out_img), .dark_lvl(dark_lvl)
  );

  // Behavioural reference state
  int m_sum[NCH], m_dark[NCH];
  bit m_seed[NCH];
  bit have_exp = 0, exp_rst, exp_valid, exp_img;
  int exp_data;
  int nvec = 0, nfail = 0, cyc = 0;

  always @(posedge clk) begin
    cyc++;
    have_exp = 1;
    exp_rst  = rst;
    if (rst) begin
      exp_valid = 0; exp_img = 0; exp_data = 0;
      for (int i = 0; i < NCH; i++) begin m_sum[i] = 0; m_dark[i] = 0; m_seed[i] = 0; end
    end else begin
      int c, r, ch, d;
      bit img, tr;
      c = pix_col; r = pix_row; ch = pix_ch; d = pix_data;
      img = (r >= 4) && (r <= AH + 3) && (c >= 18) && (c <= AW + 17);  // R5 image window
      tr  = (r >= 2) && (r <= AH + 5) && (c >= 4) && (c <= 13);       // R1 trusted window
      exp_valid = pix_valid;
      exp_img   = pix_valid && img;
      exp_data  = img ? ((d > m_dark[ch]) ? d - m_dark[ch] : 0) : d;
      if (pix_valid) begin                                             // R7 idle ignored
        if (c == 0 && r == 0) m_seed[ch] = 0;                          // R4 frame restart
        if (c == 0) m_sum[ch] = 0;
        if (tr) begin
          if (c == 13) begin                                           // R2 line close
            int mean, k;
            mean = (m_sum[ch] + d) / 10;
            k = int'(ema_shift) + 1;
            m_dark[ch] = m_seed[ch] ? m_dark[ch] + ((mean - m_dark[ch]) >>> k) : mean; // R3 / R4
            m_seed[ch] = 1;
            m_sum[ch]  = 0;
          end else m_sum[ch] += d;
        end
      end
    end
  end

  task automatic check();
    if (!have_exp) return;
    nvec++;
    if (out_valid !== exp_valid) begin
      nfail++;
      $display("FAIL %s out_valid: actual %0b expected %0b", exp_rst ? "R9" : "R7", out_valid, exp_valid);
    end
    if (exp_valid && out_data !== DW'(exp_data)) begin
      nfail++;
      $display("FAIL %s out_data: actual %0d expected %0d", exp_img ? "R5" : "R6", out_data, exp_data);
    end
    if (exp_valid && out_img !== exp_img) begin
      nfail++;
      $display("FAIL R6 out_img: actual %0b expected %0b", out_img, exp_img);
    end
    for (int i = 0; i < NCH; i++)
      if (dark_lvl[i*DW +: DW] !== DW'(m_dark[i])) begin
        nfail++;
        // estimate depends on window R1, mean R2, smoothing R3, seeding R4, channels R8, reset R9
        $display("FAIL %s dark ch%0d: actual %0d expected %0d", exp_rst ? "R9" : "R3",
                 i, dark_lvl[i*DW +: DW], m_dark[i]);
      end
  endtask

  task automatic drive(bit v, int d, int c, int r, int ch);
    @(negedge clk);
    check();
    pix_valid = v; pix_data = DW'(d); pix_col = CW'(c); pix_row = RW'(r); pix_ch = 1'(ch);
  endtask

  function automatic int pix_val(int r, int c, int base);
    bit dark_row = (r >= 2) && (r <= AH + 5);
    if (c >= 4 && c <= 13 && dark_row) return base + int'($urandom % 16);
    if (c >= 2 && c <= 15) return 3000 + int'($urandom % 500);  // leaky or shielded-row pixels
    if (c >= 18 && c <= AW + 17) return int'($urandom % (2 * base + 60));
    return int'($urandom % 4096);
  endfunction

  task automatic frame(int sh, bit dual, int gap, int b0, int b1);
    @(negedge clk);
    ema_shift = 3'(sh);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        for (int ch = 0; ch <= int'(dual); ch++) begin
          if (int'($urandom % 100) < gap)
            drive(0, $urandom % 4096, $urandom % 16, $urandom % 4, $urandom % 2);  // R7 junk idle
          drive(1, pix_val(r, c, ch ? b1 : b0), c, r, ch);
        end
  endtask

  initial begin
    repeat (3) drive(0, 0, 0, 0, 0);     // R9 reset state
    @(negedge clk); check(); rst = 1'b0;
    frame(0, 1, 0, 100, 300);            // R4 seeding, R8 independent channels
    frame(3, 1, 20, 400, 50);            // R3 smoothing, R7 gaps
    frame(7, 1, 0, 90, 1000);            // R3 deepest shift, R4 reseed
    frame(1, 0, 10, 700, 0);             // single-channel layout
    frame(2, 1, 5, 2000, 20);            // R5 saturation on low pixels
    frame(4, 1, 0, 4000, 5);
    repeat (4) drive(0, 0, 0, 0, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #1500000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule